// File: doc/BRIEF.md
# Track Buffer Cache Controller

This block sits between a host that issues sector read and write requests and a disk that delivers a stream of sector words. It keeps a small set of track buffers, three by default. Each buffer holds one track tag, a per-sector valid map and a 2-bit recency age. A read whose sector is buffered is answered from buffer storage, and the disk is not touched. A read that misses starts a fill. The fill asks the disk for the requested sector and every sector after it up to the end of the track. The words are stored as they arrive, and the requested word goes to the host as soon as it has been stored and has passed its check.

The fill target is chosen in one of two ways. A buffer that already holds the requested track is refilled in place, and its older valid sectors are kept. Otherwise the least recently used buffer is evicted. Writes always go through to the disk on the next cycle. Buffer storage is updated only when the exact sector is already valid, so a write that misses leaves every buffer, and the recency order, as they were. Sector data is modelled as one word per sector held in an internal array.

Top module: `track_cache`

## Requirements
- R1: After reset no buffer holds a track, `req_ready` is 1, and `rsp_valid`, `dsk_rd_req` and `dsk_wr_valid` are 0. The first read of any track therefore misses.
- R2: A read is a hit when a buffer holds its track and the requested sector is valid there. On a hit, in the cycle after acceptance, `rsp_valid` is 1, `rsp_err` is 0, `rsp_data` carries the buffered word and `dsk_rd_req` stays 0.
- R3: A read of a track held by no buffer is a miss. In the cycle after acceptance `dsk_rd_req` pulses for one cycle with the requested track and sector. The buffer with the oldest use (read hit, write hit or fill start) is evicted and reused.
- R4: During a fill, `req_ready` is 0 from the cycle after acceptance until the cycle after the word for the last sector (NSEC-1) is taken. Words arrive on cycles where `dsk_in_valid` is 1, in ascending sector order from the start sector, and gaps are allowed.
- R5: The first fill word is returned in the cycle after it is taken: `rsp_valid` is 1, `rsp_data` equals the word, and `rsp_err` equals the inverse of `dsk_in_ok`.
- R6: A fill word taken with `dsk_in_ok` at 0 leaves its sector invalid, so a later read of that sector misses.
- R7: A read of a buffered track at an invalid sector is a miss. The fill refills that same buffer from the requested sector, keeps its other valid sectors, and does not evict any other buffer.
- R8: Every accepted write makes `dsk_wr_valid` pulse in the next cycle, carrying the write's track, sector and data.
- R9: A write to a valid buffered sector updates the buffered word, so a later read hits and returns the new data.
- R10: A write whose sector is not valid in any buffer changes neither buffer contents nor the recency order.
- R11: Up to NBUF distinct tracks (3 by default) are held at once, and all of them hit.
- R12: The recency ages of the buffers always form a permutation of 0..NBUF-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_track | input | TW | Requested track |
| req_sector | input | log2(NSEC) | Requested sector |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data returned |
| rsp_data | output | DW | Read data |
| rsp_err | output | 1 | Returned sector failed its check |
| dsk_rd_req | output | 1 | One-cycle pulse: read track from sector to end |
| dsk_rd_track | output | TW | Track for disk read |
| dsk_rd_sector | output | log2(NSEC) | First sector for disk read |
| dsk_in_valid | input | 1 | Fill word present |
| dsk_in_data | input | DW | Fill word |
| dsk_in_ok | input | 1 | Fill word passed its check |
| dsk_wr_valid | output | 1 | One-cycle disk write pulse |
| dsk_wr_track | output | TW | Disk write track |
| dsk_wr_sector | output | log2(NSEC) | Disk write sector |
| dsk_wr_data | output | DW | Disk write data |

## Verification
The bench sweeps every sector of several tracks, so partial fills leave low sectors invalid and later reads of them refill the same buffer. A design that evicted another buffer there, or wiped the kept sectors, would show unexpected misses. Eviction order is probed after hits, write hits and write misses. A design that aged buffers on write misses, or forgot to age them on fills, would evict the wrong track, and a later read would request the disk when it should hit, or hit when it should miss. Fills are also started at sector 31, where the only word is both first and last. A failed check on the first word must raise `rsp_err` and leave the sector invalid; a design that cached it anyway would hit on the next read.

// File: rtl/trkc_pkg.sv
package trkc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } trkc_state_e;

  // True when a sector index is the final one on a track.
  function automatic logic sector_is_last(input int unsigned sec, input int unsigned nsec);
    return sec == nsec - 1;
  endfunction

  // Flat word address of a sector inside the buffer array.
  function automatic int unsigned word_addr(input int unsigned buf_idx, input int unsigned sec,
                                            input int unsigned nsec);
    return buf_idx * nsec + sec;
  endfunction

endpackage

// File: rtl/trkc_dir.sv
module trkc_dir #(
  parameter int NBUF = 3,
  parameter int NSEC = 32,
  parameter int TW   = 16,
  localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int AW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW  = $clog2(NSEC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TW-1:0]      lk_track,
  input  logic [SW-1:0]      lk_sector,
  output logic               trk_match,
  output logic [BW-1:0]      match_idx,
  output logic               sec_hit,
  output logic [BW-1:0]      victim_idx,
  input  logic               touch_en,
  input  logic [BW-1:0]      touch_idx,
  input  logic               alloc_en,
  input  logic               alloc_keep,
  input  logic [BW-1:0]      alloc_idx,
  input  logic [TW-1:0]      alloc_track,
  input  logic               mark_en,
  input  logic               mark_ok,
  input  logic [BW-1:0]      mark_idx,
  input  logic [SW-1:0]      mark_sec,
  output logic [NBUF*AW-1:0] age_flat
);

  logic [TW-1:0]   tag_q [NBUF];
  logic [NBUF-1:0] tv_q;
  logic [NSEC-1:0] vld_q [NBUF];
  logic [AW-1:0]   age_q [NBUF];
  logic [AW-1:0]   ref_age;

  // Age after a touch: the touched entry becomes youngest, younger ones grow one older.
  function automatic logic [AW-1:0] age_after(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] touched_age,
                                              input logic is_touched);
    if (is_touched)             return '0;
    else if (cur < touched_age) return cur + AW'(1);
    else                        return cur;
  endfunction

  always_comb begin
    trk_match  = 1'b0;
    match_idx  = '0;
    victim_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (tv_q[i] && tag_q[i] == lk_track) begin
        trk_match = 1'b1;
        match_idx = BW'(i);
      end
      if (age_q[i] == AW'(NBUF - 1)) victim_idx = BW'(i);
    end
    sec_hit = trk_match && vld_q[match_idx][lk_sector];
    ref_age = age_q[touch_idx];
  end

  always_comb begin
    for (int i = 0; i < NBUF; i++) age_flat[i*AW +: AW] = age_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tv_q <= '0;
      for (int i = 0; i < NBUF; i++) begin
        tag_q[i] <= '0;
        vld_q[i] <= '0;
        age_q[i] <= AW'(i);
      end
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (touch_en) age_q[i] <= age_after(age_q[i], ref_age, touch_idx == BW'(i));
        if (alloc_en && alloc_idx == BW'(i)) begin
          tag_q[i] <= alloc_track;
          tv_q[i]  <= 1'b1;
          if (!alloc_keep) vld_q[i] <= '0;
        end else if (mark_en && mark_idx == BW'(i)) begin
          vld_q[i][mark_sec] <= mark_ok;
        end
      end
    end
  end

endmodule

// File: rtl/trkc_ram.sv
module trkc_ram #(
  parameter int NBUF = 3,
  parameter int NSEC = 32,
  parameter int DW   = 16,
  localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW  = $clog2(NSEC),
  localparam int DEPTH = NBUF * NSEC,
  localparam int AD  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] widx,
  input  logic [SW-1:0] wsec,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] ridx,
  input  logic [SW-1:0] rsec,
  output logic [DW-1:0] rdata
);
  import trkc_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AD-1:0] waddr, raddr;

  assign waddr = AD'(word_addr(int'(widx), int'(wsec), NSEC));
  assign raddr = AD'(word_addr(int'(ridx), int'(rsec), NSEC));
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

endmodule

// File: rtl/track_cache.sv
module track_cache #(
  parameter int NBUF = 3,
  parameter int NSEC = 32,
  parameter int TW   = 16,
  parameter int DW   = 16,
  localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int AW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW  = $clog2(NSEC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [TW-1:0] req_track,
  input  logic [SW-1:0] req_sector,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          dsk_rd_req,
  output logic [TW-1:0] dsk_rd_track,
  output logic [SW-1:0] dsk_rd_sector,
  input  logic          dsk_in_valid,
  input  logic [DW-1:0] dsk_in_data,
  input  logic          dsk_in_ok,
  output logic          dsk_wr_valid,
  output logic [TW-1:0] dsk_wr_track,
  output logic [SW-1:0] dsk_wr_sector,
  output logic [DW-1:0] dsk_wr_data
);
  import trkc_pkg::*;

  trkc_state_e state_q;
  logic [BW-1:0] fill_buf_q;
  logic [SW-1:0] fill_sec_q;
  logic          first_q;

  logic          trk_match, sec_hit;
  logic [BW-1:0] match_idx, victim_idx, fill_pick;
  logic [NBUF*AW-1:0] age_flat;
  logic [DW-1:0] ram_rdata;

  // Named events, also observed by the checker.
  logic acc, wr_acc;
  logic rd_hit_evt, rd_miss_evt, wr_hit_evt, wr_miss_evt;
  logic fill_word, fill_first_evt, fill_last;
  logic ram_we;

  assign req_ready      = (state_q == ST_IDLE) && !rst;
  assign acc            = req_valid && req_ready;
  assign wr_acc         = acc && req_write;
  assign rd_hit_evt     = acc && !req_write && sec_hit;
  assign rd_miss_evt    = acc && !req_write && !sec_hit;
  assign wr_hit_evt     = wr_acc && sec_hit;
  assign wr_miss_evt    = wr_acc && !sec_hit;
  assign fill_word      = (state_q == ST_FILL) && dsk_in_valid;
  assign fill_first_evt = fill_word && first_q;
  assign fill_last      = fill_word && sector_is_last(int'(fill_sec_q), NSEC);
  assign fill_pick      = trk_match ? match_idx : victim_idx;
  assign ram_we         = wr_hit_evt || fill_word;

  trkc_dir #(.NBUF(NBUF), .NSEC(NSEC), .TW(TW)) u_dir (
    .clk        (clk),
    .rst        (rst),
    .lk_track   (req_track),
    .lk_sector  (req_sector),
    .trk_match  (trk_match),
    .match_idx  (match_idx),
    .sec_hit    (sec_hit),
    .victim_idx (victim_idx),
    .touch_en   (rd_hit_evt || wr_hit_evt || rd_miss_evt),
    .touch_idx  (rd_miss_evt ? fill_pick : match_idx),
    .alloc_en   (rd_miss_evt),
    .alloc_keep (trk_match),
    .alloc_idx  (fill_pick),
    .alloc_track(req_track),
    .mark_en    (fill_word),
    .mark_ok    (dsk_in_ok),
    .mark_idx   (fill_buf_q),
    .mark_sec   (fill_sec_q),
    .age_flat   (age_flat)
  );

  trkc_ram #(.NBUF(NBUF), .NSEC(NSEC), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .widx (fill_word ? fill_buf_q : match_idx),
    .wsec (fill_word ? fill_sec_q : req_sector),
    .wdata(fill_word ? dsk_in_data : req_wdata),
    .ridx (match_idx),
    .rsec (req_sector),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      fill_buf_q    <= '0;
      fill_sec_q    <= '0;
      first_q       <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_err       <= 1'b0;
      dsk_rd_req    <= 1'b0;
      dsk_rd_track  <= '0;
      dsk_rd_sector <= '0;
      dsk_wr_valid  <= 1'b0;
      dsk_wr_track  <= '0;
      dsk_wr_sector <= '0;
      dsk_wr_data   <= '0;
    end else begin
      rsp_valid <= rd_hit_evt || fill_first_evt;
      rsp_err   <= fill_first_evt && !dsk_in_ok;
      if (rd_hit_evt)          rsp_data <= ram_rdata;
      else if (fill_first_evt) rsp_data <= dsk_in_data;

      dsk_rd_req <= rd_miss_evt;
      if (rd_miss_evt) begin
        dsk_rd_track  <= req_track;
        dsk_rd_sector <= req_sector;
      end

      dsk_wr_valid <= wr_acc;
      if (wr_acc) begin
        dsk_wr_track  <= req_track;
        dsk_wr_sector <= req_sector;
        dsk_wr_data   <= req_wdata;
      end

      case (state_q)
        ST_IDLE: if (rd_miss_evt) begin
          state_q    <= ST_FILL;
          fill_buf_q <= fill_pick;
          fill_sec_q <= req_sector;
          first_q    <= 1'b1;
        end
        ST_FILL: if (fill_word) begin
          fill_sec_q <= fill_sec_q + SW'(1);
          first_q    <= 1'b0;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trkc_chk.sv
module trkc_chk #(
  parameter int NBUF = 3,
  parameter int AW   = 2,
  parameter int SW   = 5,
  parameter int TW   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [TW-1:0]      req_track,
  input logic [SW-1:0]      req_sector,
  input logic               rsp_valid,
  input logic               dsk_rd_req,
  input logic [SW-1:0]      dsk_rd_sector,
  input logic               dsk_wr_valid,
  input logic [TW-1:0]      dsk_wr_track,
  input logic [NBUF*AW-1:0] age_flat,
  input logic               rd_hit_evt,
  input logic               rd_miss_evt,
  input logic               wr_miss_evt,
  input logic               ram_we,
  input logic               fill_first_evt,
  input logic               fill_last
);

  logic [(2**AW)-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NBUF; i++) seen[age_flat[i*AW +: AW]] = 1'b1;
  end

  assert_ages_distinct_R12: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == NBUF);

  assert_hit_no_disk_R2: assert property (@(posedge clk) disable iff (rst)
    rd_hit_evt |=> rsp_valid && !dsk_rd_req);

  assert_miss_request_R3: assert property (@(posedge clk) disable iff (rst)
    rd_miss_evt |=> dsk_rd_req && dsk_rd_sector == $past(req_sector) && !req_ready);

  assert_rdreq_cause_R3: assert property (@(posedge clk) disable iff (rst)
    dsk_rd_req |-> $past(rd_miss_evt));

  assert_fill_end_R4: assert property (@(posedge clk) disable iff (rst)
    fill_last |=> req_ready);

  assert_first_release_R5: assert property (@(posedge clk) disable iff (rst)
    fill_first_evt |=> rsp_valid);

  assert_wr_through_R8: assert property (@(posedge clk) disable iff (rst)
    dsk_wr_valid |-> $past(req_valid && req_ready && req_write) && dsk_wr_track == $past(req_track));

  assert_wr_miss_no_store_R10: assert property (@(posedge clk) disable iff (rst)
    wr_miss_evt |-> !ram_we);

endmodule

bind track_cache trkc_chk #(.NBUF(NBUF), .AW(AW), .SW(SW), .TW(TW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_track     (req_track),
  .req_sector    (req_sector),
  .rsp_valid     (rsp_valid),
  .dsk_rd_req    (dsk_rd_req),
  .dsk_rd_sector (dsk_rd_sector),
  .dsk_wr_valid  (dsk_wr_valid),
  .dsk_wr_track  (dsk_wr_track),
  .age_flat      (age_flat),
  .rd_hit_evt    (rd_hit_evt),
  .rd_miss_evt   (rd_miss_evt),
  .wr_miss_evt   (wr_miss_evt),
  .ram_we        (ram_we),
  .fill_first_evt(fill_first_evt),
  .fill_last     (fill_last)
);

// File: tb/tb_track_cache.sv
`timescale 1ns/1ps
module tb_track_cache;
  localparam int NB = 3;
  localparam int NS = 32;
  localparam int NK = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_track = '0;
  logic [4:0]  req_sector = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_data;
  logic        dsk_rd_req;
  logic [15:0] dsk_rd_track;
  logic [4:0]  dsk_rd_sector;
  logic        dsk_in_valid = 1'b0, dsk_in_ok = 1'b0;
  logic [15:0] dsk_in_data = '0;
  logic        dsk_wr_valid;
  logic [15:0] dsk_wr_track, dsk_wr_data;
  logic [4:0]  dsk_wr_sector;

  always #2.5 clk = ~clk;

  track_cache dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_track(req_track), .req_sector(req_sector), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .dsk_rd_req(dsk_rd_req), .dsk_rd_track(dsk_rd_track), .dsk_rd_sector(dsk_rd_sector),
    .dsk_in_valid(dsk_in_valid), .dsk_in_data(dsk_in_data), .dsk_in_ok(dsk_in_ok),
    .dsk_wr_valid(dsk_wr_valid), .dsk_wr_track(dsk_wr_track),
    .dsk_wr_sector(dsk_wr_sector), .dsk_wr_data(dsk_wr_data)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // Disk image and an independent timestamp-based cache model.
  logic [15:0] img [NK][NS];
  int  tagm [NB];
  bit  tvm  [NB];
  bit  vm   [NB][NS];
  int  lastm [NB];
  int  tnow = 0;

  function automatic logic [15:0] trk_of(input int k);
    return 16'(k * 4099 + 17);
  endfunction

  function automatic int find_buf(input int k);
    for (int b = 0; b < NB; b++) if (tvm[b] && tagm[b] == k) return b;
    return -1;
  endfunction

  function automatic int oldest();
    int o = 0;
    for (int b = 1; b < NB; b++) if (lastm[b] < lastm[o]) o = b;
    return o;
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input int k, input int s, input int bad_sec, input string tag);
    int  b    = find_buf(k);
    bit  hit  = (b >= 0) && vm[b][s];
    string t  = (tag != "") ? tag : hit ? "R2" : (b >= 0) ? "R7" : "R3";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_track = trk_of(k); req_sector = 5'(s);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(!dsk_rd_req && rsp_valid && !rsp_err && rsp_data == img[k][s], t,
          {dsk_rd_req, rsp_valid, rsp_err, rsp_data}, {3'b010, img[k][s]});
      lastm[b] = tnow++;
    end else begin
      chk(dsk_rd_req && dsk_rd_track == trk_of(k) && dsk_rd_sector == 5'(s), t,
          {dsk_rd_req, dsk_rd_track, dsk_rd_sector}, {1'b1, trk_of(k), 5'(s)});
      if (s < NS - 1) chk(req_ready == 1'b0, "R4", 32'(req_ready), 32'd0);
      if (b < 0) begin
        b = oldest();
        for (int x = 0; x < NS; x++) vm[b][x] = 1'b0;
      end
      tagm[b] = k; tvm[b] = 1'b1; lastm[b] = tnow++;
      for (int x = s; x < NS; x++) begin
        if (x != s && x % 7 == 3) begin
          dsk_in_valid = 1'b0;
          @(negedge clk);
        end
        dsk_in_valid = 1'b1; dsk_in_data = img[k][x]; dsk_in_ok = (x != bad_sec);
        vm[b][x] = (x != bad_sec);
        @(negedge clk);
        if (x == s) begin
          if (x == bad_sec)
            chk(rsp_valid && rsp_err, "R5", {rsp_valid, rsp_err}, 2'b11);
          else
            chk(rsp_valid && !rsp_err && rsp_data == img[k][x], "R5",
                {rsp_valid, rsp_err, rsp_data}, {2'b10, img[k][x]});
        end
      end
      dsk_in_valid = 1'b0; dsk_in_ok = 1'b0;
      chk(req_ready == 1'b1, "R4", 32'(req_ready), 32'd1);
    end
  endtask

  task automatic do_write(input int k, input int s, input logic [15:0] d);
    int b   = find_buf(k);
    bit hit = (b >= 0) && vm[b][s];
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_track = trk_of(k); req_sector = 5'(s); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(dsk_wr_valid && dsk_wr_track == trk_of(k) && dsk_wr_sector == 5'(s) && dsk_wr_data == d
        && !dsk_rd_req, "R8", {dsk_wr_valid, dsk_wr_sector, dsk_wr_data}, {1'b1, 5'(s), d});
    img[k][s] = d;
    if (hit) lastm[b] = tnow++;
  endtask

  initial begin
    for (int k = 0; k < NK; k++)
      for (int s = 0; s < NS; s++)
        img[k][s] = 16'((k * NS + s) * 40503) ^ 16'h5A5A;
    for (int b = 0; b < NB; b++) begin
      tvm[b] = 1'b0; tagm[b] = -1; lastm[b] = -1 - b;
      for (int x = 0; x < NS; x++) vm[b][x] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !dsk_rd_req && !dsk_wr_valid, "R1",
        {req_ready, rsp_valid, dsk_rd_req, dsk_wr_valid}, 4'b1000);
    do_read(0, 0, -1, "R1");
    do_read(1, 5, -1, "");
    do_read(2, 10, -1, "");
    // Sweep all sectors: low sectors refill the same buffer (R7), others hit (R2).
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < NS; s++) do_read(k, s, -1, "");
    for (int k = 0; k < 3; k++) do_read(k, 31, -1, "R11");
    // Recency: touch track 0, then a new track evicts the oldest (R3).
    do_read(0, 3, -1, "");
    do_read(3, 0, -1, "R3");
    do_read(1, 31, -1, "R3");
    for (int k = 0; k < 4; k++) do_read(k, 30, -1, "");
    // Write hit updates the buffer (R9).
    do_write(0, 7, 16'hBEEF);
    do_read(0, 7, -1, "R9");
    // Write miss changes neither contents nor recency (R10).
    do_write(4, 2, 16'h1234);
    for (int k = 0; k < NK; k++) if (find_buf(k) >= 0) do_read(k, 31, -1, "R10");
    do_read(5, 0, -1, "R10");
    for (int k = 0; k < NK; k++) if (find_buf(k) >= 0) do_read(k, 20, -1, "R10");
    // Write to a buffered track below the fill start: stays a miss (R7).
    do_read(6, 16, -1, "");
    do_write(6, 4, 16'hCAFE);
    do_read(6, 4, -1, "R7");
    do_read(6, 20, -1, "R7");
    // Failed checks (R5, R6).
    do_read(7, 20, 25, "");
    do_read(7, 25, -1, "R6");
    do_read(7, 24, -1, "");
    do_read(4, 3, 3, "R5");
    do_read(4, 3, -1, "R6");
    // Closing mixed sweep over all tracks.
    for (int k = 0; k < NK; k++) begin
      do_read(k, 13, -1, "");
      do_read(k, 0, -1, "");
      do_read(k, 31, -1, "");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule